// File: doc/BRIEF.md
# Video Memory Function-Code Decoder

This block sits between a host write port and a byte-wide video memory. Each host write carries a column, a row, a 3-bit function code and a data byte. The function code picks one of five actions. The block can write a single pixel byte directly. It can copy a whole row from an internal row-wide shift register into memory, or load such a row from memory into the shift register. It can also hand the write to an outside register handler or an outside XY-address handler. Codes it does not support raise an error pulse. A second memory of the same size, the latch plane, is written in step with every data write of the video memory.

Addresses are formed from the row shifted by a row-shift amount and combined with the column. A two-bit page field from the control word can be placed into the upper address bits. Row transfers take one byte per clock. While a transfer runs, a busy output is high and host writes are dropped. Peek ports give combinational read access to both memories and to the shift register.

Top module: `vram_func_decoder`

## Requirements
- R1: A write with function code 0 or 2 sets `regStrobe` high for the following cycle. In that cycle `fwdAddr` holds the write's column and `fwdData` holds its data byte. Memory and the shift register are left as they were.
- R2: A write with function code 1 sets `xyStrobe` high for the following cycle, with the same `fwdAddr`/`fwdData` contents as in R1. Memory is left as it was.
- R3: Function code 3 is a direct write. Its address is ((row << ROW_SHIFT) | column) truncated to ADDR_W bits. The data byte goes into the video memory and `latchByte` goes into the latch plane at that address, and both are visible on the peek ports after the accepting edge.
- R4: When bit 6 of `ctrlWord` is 1, `ctrlWord[1:0]` is ORed into address bits PAGE_LSB+1:PAGE_LSB for codes 3, 4 and 5. When bit 6 is 0, bits 1:0 have no effect.
- R5: Function code 4 copies all 2^ROW_SHIFT shift-register bytes into video memory, with byte i going to row base + i. The row base is ((column << ROW_SHIFT) | page bits) truncated to ADDR_W bits.
- R6: During a code-4 transfer, every latch-plane byte of the destination row receives the `latchByte` value that was present when the write was accepted.
- R7: Function code 5 loads shift-register byte i from video memory at row base + i, with the row base formed as in R5.
- R8: After an accepted code 4 or 5, `busy` is high for exactly 2^ROW_SHIFT cycles, starting at the accepting edge. Host writes made while `busy` is high change no memory, no shift-register byte and no strobe.
- R9: Function codes 6 and 7 set `errFlag` for the following cycle and change no memory or shift-register byte.
- R10: Synchronous active-high reset clears every shift-register byte to 0 and drives `busy`, `errFlag`, `regStrobe` and `xyStrobe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWe | input | 1 | Host write strobe |
| hostCol | input | COL_W | Column / address adjustment |
| hostRow | input | ROW_W | Row |
| hostFunc | input | 3 | Function code |
| hostData | input | 8 | Write data byte |
| ctrlWord | input | CTRL_W | Control word: bit 6 page enable, bits 1:0 page |
| latchByte | input | 8 | Value for the latch plane |
| busy | output | 1 | Row transfer in progress |
| regStrobe | output | 1 | Register-access forward pulse |
| xyStrobe | output | 1 | XY-access forward pulse |
| fwdAddr | output | COL_W | Column forwarded with a strobe |
| fwdData | output | 8 | Data forwarded with a strobe |
| errFlag | output | 1 | Unsupported function pulse |
| peekAddr | input | ADDR_W | Memory peek address |
| vramPeek | output | 8 | Video memory byte at peekAddr |
| latchPeek | output | 8 | Latch plane byte at peekAddr |
| shiftIdx | input | ROW_SHIFT | Shift-register byte select |
| shiftPeek | output | 8 | Shift-register byte at shiftIdx |

## Verification
The hardest case to reach is a host write that arrives while a row transfer is still running. The bench issues a row load and then, before `busy` can drop, sends a direct write, a register-access write and an unsupported code. It then checks that none of them left a trace in memory, in the shift register or on the strobes. A second hard case is a row store whose contents are not trivial. To reach it, the bench first fills the whole memory with arithmetic patterns and loads the shift register from one page. It then stores that row into a different row, on a different page, with a new latch value.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [2:0] {
    FN_REG_A  = 3'd0,
    FN_XY     = 3'd1,
    FN_REG_B  = 3'd2,
    FN_DIRECT = 3'd3,
    FN_STORE  = 3'd4,
    FN_LOAD   = 3'd5
  } funcCode_t;

  localparam int PAGE_EN_BIT = 6;

  typedef struct packed {
    logic directWe;
    logic captureBase;
    logic storeStep;
    logic loadStep;
  } dpCtl_t;
endpackage

// File: rtl/vfd_control.sv
module vfd_control #(
  parameter int ROW_SHIFT = 3,
  parameter int COL_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostWe,
  input  logic [2:0]            hostFunc,
  input  logic [COL_W-1:0]      hostCol,
  input  logic [7:0]            hostData,
  output vfd_pkg::dpCtl_t       ctl,
  output logic [ROW_SHIFT-1:0]  stepIdx,
  output logic                  busy,
  output logic                  regStrobe,
  output logic                  xyStrobe,
  output logic                  errFlag,
  output logic [COL_W-1:0]      fwdAddr,
  output logic [7:0]            fwdData
);
  import vfd_pkg::*;

  localparam logic [ROW_SHIFT-1:0] LAST_IDX = {ROW_SHIFT{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_LOAD} state_t;

  state_t state, stateNext;
  logic   accept;
  logic   isReg, isXy, isErr;

  assign accept = hostWe && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    isReg = 1'b0;
    isXy  = 1'b0;
    isErr = 1'b0;
    ctl   = '0;
    stateNext = state;
    if (accept) begin
      case (hostFunc)
        FN_REG_A, FN_REG_B: isReg = 1'b1;
        FN_XY:              isXy  = 1'b1;
        FN_DIRECT:          ctl.directWe = 1'b1;
        FN_STORE: begin
          ctl.captureBase = 1'b1;
          stateNext = ST_STORE;
        end
        FN_LOAD: begin
          ctl.captureBase = 1'b1;
          stateNext = ST_LOAD;
        end
        default:            isErr = 1'b1;
      endcase
    end
    if (state == ST_STORE) ctl.storeStep = 1'b1;
    if (state == ST_LOAD)  ctl.loadStep  = 1'b1;
    if (busy && stepIdx == LAST_IDX) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      regStrobe <= 1'b0;
      xyStrobe  <= 1'b0;
      errFlag   <= 1'b0;
      fwdAddr   <= '0;
      fwdData   <= '0;
    end else begin
      state     <= stateNext;
      regStrobe <= isReg;
      xyStrobe  <= isXy;
      errFlag   <= isErr;
      if (isReg || isXy) begin
        fwdAddr <= hostCol;
        fwdData <= hostData;
      end
      if (busy) stepIdx <= stepIdx + 1'b1;
      else      stepIdx <= '0;
    end
  end
endmodule

// File: rtl/vfd_datapath.sv
module vfd_datapath #(
  parameter int ADDR_W    = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int ROW_SHIFT = 3,
  parameter int PAGE_LSB  = 6,
  parameter int CTRL_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  vfd_pkg::dpCtl_t      ctl,
  input  logic [ROW_SHIFT-1:0] stepIdx,
  input  logic [COL_W-1:0]     hostCol,
  input  logic [ROW_W-1:0]     hostRow,
  input  logic [7:0]           hostData,
  input  logic [CTRL_W-1:0]    ctrlWord,
  input  logic [7:0]           latchByte,
  input  logic [ADDR_W-1:0]    peekAddr,
  output logic [7:0]           vramPeek,
  output logic [7:0]           latchPeek,
  input  logic [ROW_SHIFT-1:0] shiftIdx,
  output logic [7:0]           shiftPeek
);
  import vfd_pkg::*;

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ROW_LEN = 1 << ROW_SHIFT;
  localparam int EXT_W   = ROW_W + COL_W + ROW_SHIFT + PAGE_LSB + 2;

  logic [7:0] vramMem  [DEPTH];
  logic [7:0] latchMem [DEPTH];
  logic [7:0] shiftReg [ROW_LEN];

  logic [1:0]        pageBits;
  logic [EXT_W-1:0]  pageExt, directRaw, rowRaw;
  logic [ADDR_W-1:0] directAddr, rowBase, baseReg, stepAddr, wrAddr;
  logic [7:0]        latchHold, wrVram, wrLatch, loadByte;
  logic              writeEn;

  // Address formation: mask direct address first, then merge the page field.
  always_comb begin
    pageBits   = ctrlWord[PAGE_EN_BIT] ? ctrlWord[1:0] : 2'b00;
    pageExt    = EXT_W'(pageBits) << PAGE_LSB;
    directRaw  = (EXT_W'(hostRow) << ROW_SHIFT) | EXT_W'(hostCol);
    directAddr = directRaw[ADDR_W-1:0] | pageExt[ADDR_W-1:0];
    rowRaw     = (EXT_W'(hostCol) << ROW_SHIFT) | pageExt;
    rowBase    = rowRaw[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg   <= '0;
      latchHold <= '0;
    end else if (ctl.captureBase) begin
      baseReg   <= rowBase;
      latchHold <= latchByte;
    end
  end

  assign stepAddr = baseReg | ADDR_W'(stepIdx);
  assign writeEn  = ctl.directWe | ctl.storeStep;
  assign wrAddr   = ctl.storeStep ? stepAddr : directAddr;
  assign wrVram   = ctl.storeStep ? shiftReg[stepIdx] : hostData;
  assign wrLatch  = ctl.storeStep ? latchHold : latchByte;

  always_ff @(posedge clk) begin
    if (writeEn) begin
      vramMem[wrAddr]  <= wrVram;
      latchMem[wrAddr] <= wrLatch;
    end
  end

  assign loadByte = vramMem[stepAddr];

  for (genvar g = 0; g < ROW_LEN; g++) begin : gShift
    always_ff @(posedge clk) begin
      if (rst)
        shiftReg[g] <= '0;
      else if (ctl.loadStep && stepIdx == ROW_SHIFT'(g))
        shiftReg[g] <= loadByte;
    end
  end

  assign vramPeek  = vramMem[peekAddr];
  assign latchPeek = latchMem[peekAddr];
  assign shiftPeek = shiftReg[shiftIdx];
endmodule

// File: rtl/vram_func_decoder.sv
module vram_func_decoder #(
  parameter int ADDR_W    = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int ROW_SHIFT = 3,
  parameter int PAGE_LSB  = 6,
  parameter int CTRL_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hostWe,
  input  logic [COL_W-1:0]     hostCol,
  input  logic [ROW_W-1:0]     hostRow,
  input  logic [2:0]           hostFunc,
  input  logic [7:0]           hostData,
  input  logic [CTRL_W-1:0]    ctrlWord,
  input  logic [7:0]           latchByte,
  output logic                 busy,
  output logic                 regStrobe,
  output logic                 xyStrobe,
  output logic [COL_W-1:0]     fwdAddr,
  output logic [7:0]           fwdData,
  output logic                 errFlag,
  input  logic [ADDR_W-1:0]    peekAddr,
  output logic [7:0]           vramPeek,
  output logic [7:0]           latchPeek,
  input  logic [ROW_SHIFT-1:0] shiftIdx,
  output logic [7:0]           shiftPeek
);
  vfd_pkg::dpCtl_t      ctl;
  logic [ROW_SHIFT-1:0] stepIdx;

  vfd_control #(.ROW_SHIFT(ROW_SHIFT), .COL_W(COL_W)) control_i (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostFunc(hostFunc),
    .hostCol(hostCol), .hostData(hostData), .ctl(ctl), .stepIdx(stepIdx),
    .busy(busy), .regStrobe(regStrobe), .xyStrobe(xyStrobe),
    .errFlag(errFlag), .fwdAddr(fwdAddr), .fwdData(fwdData)
  );

  vfd_datapath #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ROW_SHIFT(ROW_SHIFT), .PAGE_LSB(PAGE_LSB), .CTRL_W(CTRL_W)
  ) datapath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .stepIdx(stepIdx),
    .hostCol(hostCol), .hostRow(hostRow), .hostData(hostData),
    .ctrlWord(ctrlWord), .latchByte(latchByte),
    .peekAddr(peekAddr), .vramPeek(vramPeek), .latchPeek(latchPeek),
    .shiftIdx(shiftIdx), .shiftPeek(shiftPeek)
  );
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int ROW_SHIFT = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       hostWe,
  input logic [2:0] hostFunc,
  input logic       busy,
  input logic       regStrobe,
  input logic       xyStrobe,
  input logic       errFlag
);
  localparam int ROW_LEN = 1 << ROW_SHIFT;

  logic [ROW_SHIFT+1:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst || !busy) busyRun <= '0;
    else              busyRun <= busyRun + 1'b1;
  end

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !busy && !errFlag && !regStrobe && !xyStrobe);

  assert_reg_source_R1: assert property (@(posedge clk) disable iff (rst)
    regStrobe |-> $past(hostWe && !busy && (hostFunc == 3'd0 || hostFunc == 3'd2)));

  assert_xy_source_R2: assert property (@(posedge clk) disable iff (rst)
    xyStrobe |-> $past(hostWe && !busy && hostFunc == 3'd1));

  assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $past(hostWe && !busy && hostFunc[2:1] == 2'b11));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(hostWe && (hostFunc == 3'd4 || hostFunc == 3'd5)));

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> busyRun < (ROW_SHIFT + 2)'(ROW_LEN));

  assert_busy_exact_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(busyRun) == (ROW_SHIFT + 2)'(ROW_LEN - 1));

  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regStrobe, xyStrobe, errFlag}));
endmodule

bind vram_func_decoder vfd_checker #(.ROW_SHIFT(ROW_SHIFT)) checker_i (
  .clk(clk), .rst(rst), .hostWe(hostWe), .hostFunc(hostFunc),
  .busy(busy), .regStrobe(regStrobe), .xyStrobe(xyStrobe), .errFlag(errFlag)
);

// File: tb/vram_func_decoder_tb_top.sv
module vram_func_decoder_tb_top;
  localparam int AW = 8, RS = 3, PL = 6, ROWLEN = 8, DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostWe = 1'b0;
  logic [7:0] hostCol = '0, hostRow = '0, hostData = '0, latchByte = '0;
  logic [2:0] hostFunc = '0;
  logic [15:0] ctrlWord = '0;
  logic busy, regStrobe, xyStrobe, errFlag;
  logic [7:0] fwdAddr, fwdData, vramPeek, latchPeek, shiftPeek;
  logic [AW-1:0] peekAddr = '0;
  logic [RS-1:0] shiftIdx = '0;

  int checks = 0, errors = 0;
  logic [7:0] refVram [DEPTH];
  logic [7:0] refLatch [DEPTH];
  logic [7:0] refShift [ROWLEN];

  always #2 clk = ~clk;

  vram_func_decoder dut_i (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostCol(hostCol), .hostRow(hostRow),
    .hostFunc(hostFunc), .hostData(hostData), .ctrlWord(ctrlWord),
    .latchByte(latchByte), .busy(busy), .regStrobe(regStrobe),
    .xyStrobe(xyStrobe), .fwdAddr(fwdAddr), .fwdData(fwdData),
    .errFlag(errFlag), .peekAddr(peekAddr), .vramPeek(vramPeek),
    .latchPeek(latchPeek), .shiftIdx(shiftIdx), .shiftPeek(shiftPeek)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pageOf(input logic [15:0] c);
    return c[6] ? (int'(c[1:0]) << PL) : 0;
  endfunction

  function automatic int directAddr(input int row, input int col, input logic [15:0] c);
    return ((((row << RS) | col) & (DEPTH - 1)) | pageOf(c)) & (DEPTH - 1);
  endfunction

  function automatic int rowBase(input int col, input logic [15:0] c);
    return ((col << RS) | pageOf(c)) & (DEPTH - 1);
  endfunction

  task automatic hostWrite(input int fn, input int col, input int row, input int data);
    @(negedge clk);
    hostFunc = 3'(fn); hostCol = 8'(col); hostRow = 8'(row); hostData = 8'(data);
    hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic compareMem(input string req, input int a);
    peekAddr = AW'(a);
    #0.1;
    check(req, vramPeek, refVram[a]);
    check(req, latchPeek, refLatch[a]);
  endtask

  task automatic compareShift(input string req);
    for (int i = 0; i < ROWLEN; i++) begin
      shiftIdx = RS'(i);
      #0.1;
      check(req, shiftPeek, refShift[i]);
    end
  endtask

  task automatic rowLoad(input int col, input logic [15:0] c, input string req);
    int n = 0;
    int base;
    ctrlWord = c;
    base = rowBase(col, c);
    hostWrite(5, col, 0, 0);
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R8 busy length", n, ROWLEN);
    for (int i = 0; i < ROWLEN; i++) refShift[i] = refVram[base + i];
    compareShift(req);
  endtask

  task automatic rowStore(input int col, input logic [15:0] c, input int lv);
    int base;
    ctrlWord = c;
    latchByte = 8'(lv);
    base = rowBase(col, c);
    hostWrite(4, col, 0, 0);
    latchByte = 8'(lv ^ 8'hFF);
    waitIdle();
    for (int i = 0; i < ROWLEN; i++) begin
      refVram[base + i] = refShift[i];
      refLatch[base + i] = 8'(lv);
      peekAddr = AW'(base + i);
      #0.1;
      check("R5 row store data", vramPeek, refVram[base + i]);
      check("R6 row store latch fill", latchPeek, lv);
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROWLEN; i++) refShift[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 errFlag", errFlag, 0);
    check("R10 regStrobe", regStrobe, 0);
    check("R10 xyStrobe", xyStrobe, 0);
    compareShift("R10 shift cleared");

    // R3 sweep: fill every address with a direct write, no page
    ctrlWord = 16'h0003;  // page bits set but enable off: R4 no effect
    for (int a = 0; a < DEPTH; a++) begin
      latchByte = 8'(a ^ 8'h5A);
      hostWrite(3, a & 7, a >> 3, a * 7 + 3);
      refVram[a] = 8'(a * 7 + 3);
      refLatch[a] = 8'(a ^ 8'h5A);
    end
    for (int a = 0; a < DEPTH; a++) compareMem("R3 direct sweep", a);

    // R3 overlapping column bits and high row bits truncated
    latchByte = 8'h11;
    begin
      int a;
      a = directAddr(1, 8'h0F, ctrlWord);
      hostWrite(3, 8'h0F, 1, 8'hC1);
      refVram[a] = 8'hC1; refLatch[a] = 8'h11;
      compareMem("R3 column overlap", a);
      a = directAddr(8'h45, 2, ctrlWord);
      hostWrite(3, 2, 8'h45, 8'hC2);
      refVram[a] = 8'hC2; refLatch[a] = 8'h11;
      compareMem("R3 row truncation", a);
    end

    // R4 page field on direct writes, every page
    for (int p = 0; p < 4; p++) begin
      int a;
      ctrlWord = 16'h0040 | 16'(p);
      latchByte = 8'(8'h80 + p);
      a = directAddr(1, 5, ctrlWord);
      check("R4 page address", a, (p << PL) | 13);
      hostWrite(3, 5, 1, 8'hA0 + p);
      refVram[a] = 8'(8'hA0 + p); refLatch[a] = 8'(8'h80 + p);
      compareMem("R4 paged direct write", a);
    end

    // R7 row loads across pages and columns
    rowLoad(2, 16'h0000, "R7 load unpaged");
    rowLoad(1, 16'h0041, "R7 load page 1");
    rowLoad(7, 16'h0043, "R7 load page 3 high col");

    // R5/R6 store to a different row and page
    rowStore(3, 16'h0042, 8'h3C);
    rowLoad(3, 16'h0042, "R7 reload stored row");
    rowStore(0, 16'h0000, 8'hE7);

    // R8 writes during busy are ignored
    ctrlWord = 16'h0000;
    rowLoad(4, 16'h0000, "R7 load before ignore test");
    ctrlWord = 16'h0000;
    hostWrite(5, 6, 0, 0);
    for (int i = 0; i < ROWLEN; i++) refShift[i] = refVram[rowBase(6, 16'h0000) + i];
    latchByte = 8'h99;
    hostWrite(3, 0, 0, 8'h77);
    check("R8 no strobe during busy", regStrobe | xyStrobe | errFlag, 0);
    hostWrite(0, 3, 0, 8'h55);
    check("R8 register write dropped", regStrobe, 0);
    hostWrite(7, 3, 0, 8'h55);
    check("R8 error write dropped", errFlag, 0);
    waitIdle();
    compareMem("R8 memory untouched", 0);
    compareShift("R8 load still exact");

    // R1 register forwards for both codes
    hostWrite(0, 8'h9A, 3, 8'h42);
    check("R1 code0 strobe", regStrobe, 1);
    check("R1 code0 addr", fwdAddr, 8'h9A);
    check("R1 code0 data", fwdData, 8'h42);
    @(negedge clk);
    check("R1 strobe one cycle", regStrobe, 0);
    hostWrite(2, 8'h13, 0, 8'hF0);
    check("R1 code2 strobe", regStrobe, 1);
    check("R1 code2 addr", fwdAddr, 8'h13);
    check("R1 code2 data", fwdData, 8'hF0);
    // R2 XY forward
    hostWrite(1, 8'h21, 0, 8'h6B);
    check("R2 xy strobe", xyStrobe, 1);
    check("R2 xy not reg", regStrobe, 0);
    check("R2 xy addr", fwdAddr, 8'h21);
    check("R2 xy data", fwdData, 8'h6B);
    // R9 unsupported codes
    hostWrite(6, 0, 0, 8'h01);
    check("R9 code6 err", errFlag, 1);
    @(negedge clk);
    check("R9 err one cycle", errFlag, 0);
    hostWrite(7, 1, 0, 8'h02);
    check("R9 code7 err", errFlag, 1);
    compareShift("R9 shift unchanged");

    // Full memory comparison: no stray writes anywhere (R1 R2 R8 R9)
    for (int a = 0; a < DEPTH; a++) compareMem("R9 final memory", a);

    // R10 reset clears shift register again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < ROWLEN; i++) refShift[i] = 8'h00;
    compareShift("R10 shift after reset");
    check("R10 busy after reset", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule